// File: doc/BRIEF.md
# Multiplexed-Bus Machine-Cycle Sequencer

This block produces the external bus timing of a small 8-bit processor whose low address byte shares its pins with the data byte. An internal requester asks for one machine cycle at a time: an opcode fetch, a memory read or a memory write. The block then steps through that cycle's T-states, one clock each. It drives the address-latch strobe, the active-low read and write strobes, the upper address byte, the shared address/data byte and its output enable. Bytes returned by memory land in an instruction register for a fetch, or in an accumulator for a read.

The high address byte stays on its own pins for the whole cycle. The low byte appears on the shared lines only during T1. The latch strobe falls halfway through T1, so an external transparent latch can hold the low byte once the shared lines change role.

A fetch loads the program counter with the requested address. Each read first steps the counter by one and uses the new value as its address, so a fetch followed by its operand reads walks through consecutive bytes. A request made during the final T-state of a cycle starts the next cycle at once. A fetch alone therefore takes 4 T-states, a fetch with one operand takes 7, and a fetch with two operands takes 10.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is high, and after it until a request is taken: busy is 0, ale is 0, rd_n and wr_n are 1, and ad_oe is 0.
- R2: req_type codes are 0 for opcode fetch, 1 for memory read and 2 for memory write. A request is taken only when req_valid is 1 and the block is idle or in the final T-state of its current cycle. Code 3 is never taken, and the block stays idle.
- R3: An opcode fetch lasts exactly 4 T-states, and a read or a write lasts exactly 3. busy is 1 in every T-state, and after the last one the block returns to idle when no request is taken.
- R4: In T1, addr_hi carries address bits 15:8 and ad_out carries bits 7:0 with ad_oe at 1. ale is high in the first half of T1 and low in the second half, so the low byte can be latched on the falling edge of ale.
- R5: In a fetch, rd_n is 0 in T2 and T3. ir takes ad_in at the end of T3. In T4, rd_n is 1 and ad_oe is 0.
- R6: A read uses the program counter plus one as its address and stores that value back into the counter. rd_n is 0 in T2 and T3, and acc takes ad_in at the end of T3.
- R7: A fetch loads the program counter with req_addr, so following reads use req_addr+1, req_addr+2 and so on, wrapping modulo 2^16. A write leaves the counter unchanged.
- R8: In a write, wr_n is 0 only in T2, when ad_out carries req_wdata with ad_oe at 1. In T3, wr_n is back at 1 and ad_oe is 0.
- R9: rd_n and wr_n are never 0 together. ad_oe is 1 only in T1 and in T2 of a write.
- R10: A request taken in the final T-state is followed at once by its T1, with no idle cycle between, so a fetch followed by two reads occupies 10 consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A machine-cycle request is present |
| req_type | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved |
| req_addr | input | 16 | Address for a fetch or a write |
| req_wdata | input | 8 | Byte to store in a write |
| busy | output | 1 | A machine cycle is in progress |
| addr_hi | output | 8 | Upper address byte, held for the whole cycle |
| ad_out | output | 8 | Shared lines, outward value |
| ad_in | input | 8 | Shared lines, value returned by memory |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ale | output | 1 | Address latch strobe, falls in mid-T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ir | output | 8 | Instruction register |
| acc | output | 8 | Accumulator |

## Verification
A fetch run alone separates the 4-state cycle length and the T4 float from the 3-state cycles. A fetch chained to two reads shows whether the counter steps before each read, and whether a request waiting during T1 is held back until the final T-state. A write chained to a read tells apart the strobe that each cycle type drives, and shows that a write leaves the counter untouched. A fetch at the top address followed by a read checks the wrap to zero, and a request with the reserved code shows that such a request is refused. A memory model latches the low byte on the falling edge of ale and answers from it, so a wrong strobe phase shows up as a wrong ir or acc.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    CY_FETCH = 2'd0,
    CY_READ  = 2'd1,
    CY_WRITE = 2'd2
  } cyc_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } ts_e;

  localparam logic [1:0] TYPE_RESERVED = 2'd3;
endpackage

// File: rtl/bcs_seq.sv
module bcs_seq
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_type,
  output ts_e        ts_q,
  output cyc_e       cy_q,
  output ts_e        ts_d,
  output cyc_e       cy_d,
  output logic       accept
);
  logic last_ts;

  always_comb begin
    last_ts = (ts_q == TS_T4) || ((ts_q == TS_T3) && (cy_q != CY_FETCH));
    accept  = req_valid && (req_type != TYPE_RESERVED) &&
              ((ts_q == TS_IDLE) || last_ts);
  end

  always_comb begin
    cy_d = cy_q;
    ts_d = TS_IDLE;
    if (accept) begin
      ts_d = TS_T1;
      cy_d = cyc_e'(req_type);
    end else begin
      case (ts_q)
        TS_T1:   ts_d = TS_T2;
        TS_T2:   ts_d = TS_T3;
        TS_T3:   ts_d = (cy_q == CY_FETCH) ? TS_T4 : TS_IDLE;
        default: ts_d = TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q <= TS_IDLE;
      cy_q <= CY_FETCH;
    end else begin
      ts_q <= ts_d;
      cy_q <= cy_d;
    end
  end

  AST_FETCH_HAS_T4: assert property (@(posedge clk) disable iff (rst)
    (ts_q == TS_T3 && cy_q == CY_FETCH) |=> (ts_q == TS_T4)); // R3
  AST_SHORT_ENDS_T3: assert property (@(posedge clk) disable iff (rst)
    (ts_q == TS_T3 && cy_q != CY_FETCH) |=> (ts_q == TS_IDLE || ts_q == TS_T1)); // R3
  AST_T1_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (ts_q == TS_T1) |-> ($past(ts_q) == TS_IDLE || $past(ts_q) == TS_T4 ||
                         ($past(ts_q) == TS_T3 && $past(cy_q) != CY_FETCH))); // R2
endmodule

// File: rtl/bcs_regs.sv
module bcs_regs
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [1:0]    req_type,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] ad_in,
  input  ts_e           ts_q,
  input  cyc_e          cy_q,
  output logic [AW-1:0] start_addr,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc
);
  localparam logic [AW-1:0] PC_ONE = AW'(1);

  logic [AW-1:0] pc;

  always_comb begin
    start_addr = (req_type == 2'(CY_READ)) ? (pc + PC_ONE) : req_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (accept && req_type == 2'(CY_FETCH)) pc <= req_addr;
      if (accept && req_type == 2'(CY_READ))  pc <= pc + PC_ONE;
      if (ts_q == TS_T3 && cy_q == CY_FETCH)  ir <= ad_in;
      if (ts_q == TS_T3 && cy_q == CY_READ)   acc <= ad_in;
    end
  end

  AST_IR_ONLY_FETCH_T3: assert property (@(posedge clk) disable iff (rst)
    !(ts_q == TS_T3 && cy_q == CY_FETCH) |=> $stable(ir)); // R5
  AST_ACC_ONLY_READ_T3: assert property (@(posedge clk) disable iff (rst)
    !(ts_q == TS_T3 && cy_q == CY_READ) |=> $stable(acc)); // R6
  AST_PC_WRITE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (accept && req_type == 2'(CY_WRITE)) |=> $stable(pc)); // R7
endmodule

// File: rtl/bcs_pins.sv
module bcs_pins
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  ts_e           ts_d,
  input  cyc_e          cy_d,
  input  ts_e           ts_q,
  input  cyc_e          cy_q,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ad_oe,
  output logic [DW-1:0] ad_out,
  output logic [AW-DW-1:0] addr_hi
);
  logic          ale_rise;
  logic          ale_fall;
  logic [DW-1:0] wdata_q;
  logic          wr_data_ph;

  always_comb wr_data_ph = (ts_d == TS_T2) && (cy_d == CY_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_rise <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
      addr_hi  <= '0;
      wdata_q  <= '0;
    end else begin
      ale_rise <= (ts_d == TS_T1);
      rd_n     <= !(((ts_d == TS_T2) || (ts_d == TS_T3)) && (cy_d != CY_WRITE));
      wr_n     <= !wr_data_ph;
      ad_oe    <= (ts_d == TS_T1) || wr_data_ph;
      if (accept) begin
        ad_out  <= start_addr[DW-1:0];
        addr_hi <= start_addr[AW-1:DW];
        wdata_q <= req_wdata;
      end else if (wr_data_ph) begin
        ad_out <= wdata_q;
      end
    end
  end

  // second half of T1: a falling-edge copy cancels the strobe
  always_ff @(negedge clk) begin
    if (rst) ale_fall <= 1'b0;
    else     ale_fall <= ale_rise;
  end

  always_comb ale = ale_rise & ~ale_fall;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R9
  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (ts_q == TS_T1 || (ts_q == TS_T2 && cy_q == CY_WRITE))); // R9
  AST_ALE_IN_T1: assert property (@(posedge clk) disable iff (rst)
    ale_rise |-> (ts_q == TS_T1)); // R4
  AST_WR_ONLY_T2: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (ts_q == TS_T2 && cy_q == CY_WRITE)); // R8
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_type,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             busy,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    ad_out,
  input  logic [DW-1:0]    ad_in,
  output logic             ad_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ir,
  output logic [DW-1:0]    acc
);
  ts_e           ts_q, ts_d;
  cyc_e          cy_q, cy_d;
  logic          accept;
  logic [AW-1:0] start_addr;

  bcs_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .ts_q(ts_q), .cy_q(cy_q), .ts_d(ts_d), .cy_d(cy_d), .accept(accept)
  );

  bcs_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .accept(accept), .req_type(req_type),
    .req_addr(req_addr), .ad_in(ad_in), .ts_q(ts_q), .cy_q(cy_q),
    .start_addr(start_addr), .ir(ir), .acc(acc)
  );

  bcs_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .accept(accept), .ts_d(ts_d), .cy_d(cy_d),
    .ts_q(ts_q), .cy_q(cy_q), .start_addr(start_addr), .req_wdata(req_wdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .ad_out(ad_out),
    .addr_hi(addr_hi)
  );

  always_comb busy = (ts_q != TS_IDLE);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_n && wr_n && !ad_oe)); // R1
endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  localparam logic [1:0] TY_F = 2'd0, TY_R = 2'd1, TY_W = 2'd2, TY_X = 2'd3;

  typedef struct {
    logic [1:0]  ty;
    logic [15:0] a;
    logic [7:0]  d;
    bit          follow;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_type = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_out, ad_in, ir, acc, addr_hi;
  logic busy, ad_oe, ale, rd_n, wr_n;
  logic [15:0] lat_q = '0;
  logic [15:0] pc_m = '0;
  int n_run = 0, n_fail = 0;
  item_t q[$];

  always #4 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .ir(ir), .acc(acc)
  );

  function automatic logic [7:0] memv(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: external latch on the falling strobe
  always @(negedge ale) lat_q <= {addr_hi, ad_out};
  assign ad_in = !rd_n ? memv(lat_q) : 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic issue(input logic [1:0] ty, input logic [15:0] a,
                       input logic [7:0] d, input bit follow);
    item_t it;
    it.ty = ty; it.d = d; it.follow = follow;
    if (ty == TY_R) begin pc_m = pc_m + 16'd1; it.a = pc_m; end
    else begin it.a = a; if (ty == TY_F) pc_m = a; end
    q.push_back(it);
    req_valid = 1'b1; req_type = ty; req_addr = a; req_wdata = d;
    do begin @(posedge clk); #2; end while (ale !== 1'b1);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #2; end while (busy);
    @(posedge clk); #2;
  endtask

  // monitor: pops expected items at each T1 and walks the T-states
  initial begin
    item_t it;
    int len;
    bit pend;
    pend = 0;
    wait (!rst);
    forever begin
      if (!pend) begin @(posedge clk); #2; end
      pend = 0;
      if (ale === 1'b1) begin
        if (q.size() == 0) begin
          chk(0, "R2", "T1 without request", 1, 0);
          continue;
        end
        it = q.pop_front();
        len = (it.ty == TY_F) ? 4 : 3;
        chk(addr_hi == it.a[15:8], "R4", "addr_hi T1", addr_hi, it.a[15:8]);
        chk(ad_oe && ad_out == it.a[7:0], "R4", "low addr T1", ad_out, it.a[7:0]);
        chk(rd_n && wr_n && busy, "R9", "strobes T1", {rd_n, wr_n, busy}, 3'b111);
        #4;
        chk(ale == 1'b0, "R4", "ale mid-T1 fall", ale, 0);
        for (int k = 2; k <= len; k++) begin
          @(posedge clk); #2;
          chk(rd_n == !((k == 2 || k == 3) && it.ty != TY_W),
              (it.ty == TY_F) ? "R5" : "R6", $sformatf("rd_n T%0d", k), rd_n,
              !((k == 2 || k == 3) && it.ty != TY_W));
          chk(wr_n == !(k == 2 && it.ty == TY_W), "R8", $sformatf("wr_n T%0d", k),
              wr_n, !(k == 2 && it.ty == TY_W));
          chk(ad_oe == (k == 2 && it.ty == TY_W), "R9", $sformatf("ad_oe T%0d", k),
              ad_oe, (k == 2 && it.ty == TY_W));
          chk(busy && !ale, "R3", $sformatf("busy T%0d", k), {busy, ale}, 2'b10);
          if (k == 2 && it.ty == TY_W)
            chk(ad_out == it.d, "R8", "write data", ad_out, it.d);
          if (k == 2 && it.ty != TY_W)
            chk(lat_q == it.a, "R4", "latched address", lat_q, it.a);
          if (k == 4)
            chk(ir == memv(it.a), "R5", "ir capture", ir, memv(it.a));
        end
        @(posedge clk); #2;
        if (it.ty == TY_R)
          chk(acc == memv(it.a), "R6", "acc capture", acc, memv(it.a));
        if (it.follow)
          chk(ale == 1'b1, "R10", "next T1 follows", ale, 1);
        else
          chk(!busy && !ale, "R3", "idle after cycle", {busy, ale}, 0);
        if (ale === 1'b1) pend = 1;
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(!busy && !ale && rd_n && wr_n && !ad_oe, "R1", "in reset",
        {busy, ale, rd_n, wr_n, ad_oe}, 5'b00110);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk(!busy && !ale && rd_n && wr_n && !ad_oe, "R1", "after reset",
        {busy, ale, rd_n, wr_n, ad_oe}, 5'b00110);

    // lone fetch
    issue(TY_F, 16'h1234, 8'h00, 0);
    wait_idle();
    // fetch with two operand reads: R7 counter walk, R10 chaining
    issue(TY_F, 16'h2000, 8'h00, 1);
    issue(TY_R, 16'h0000, 8'h00, 1);
    issue(TY_R, 16'h0000, 8'h00, 0);
    wait_idle();
    // write then read: write keeps the counter (R7)
    issue(TY_W, 16'h8005, 8'hC3, 1);
    issue(TY_R, 16'h0000, 8'h00, 0);
    wait_idle();
    // reserved code refused (R2)
    req_valid = 1'b1; req_type = TY_X; req_addr = 16'h4444;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      chk(!busy && !ale, "R2", "reserved type", {busy, ale}, 0);
    end
    req_valid = 1'b0;
    // counter wrap (R7)
    issue(TY_F, 16'hFFFF, 8'h00, 1);
    issue(TY_R, 16'h0000, 8'h00, 0);
    wait_idle();
    issue(TY_W, 16'h00A0, 8'h5A, 0);
    wait_idle();
    repeat (3) @(posedge clk);
    #2;
    chk(q.size() == 0, "R3", "all cycles seen", q.size(), 0);
    summary();
    $finish;
  end
endmodule